// File: doc/BRIEF.md
# Software Write-Protect Command Sequencer

This block sits beside the page-load controller of an electrically erasable memory. It watches every host write cycle for fixed address/data command sequences. A three-write sequence arms protection. A six-write sequence arms its release. Neither takes effect until the program period that follows has ended. It also decides, for each write, whether the byte is loaded as real data, dropped as a command byte, or refused.

A refused write is not silent. It raises `suppress`, which tells the controller to run a timed program cycle that leaves the array unchanged. Reads during that cycle then behave as status polling. While protection is on, the host can still store a page: it issues the three-write sequence first, and this opens a load window. The window closes at the byte-load timeout.

Top module: `sdp_cmd_seq`

## Requirements
- R1: After reset, `protect` is 0 and no step of any sequence is pending.
- R2: `allow` and `suppress` are combinational on the strobe cycle. They are never both high, and neither is high without `wr_stb`. With `protect` at 0, every write that is not a command step gives `allow`=1 and `suppress`=0.
- R3: The enable sequence is 8'hAA to 15'h5555, then 8'h55 to 15'h2AAA, then 8'hA0 to 15'h5555. Each of these writes gives `allow`=0 and `suppress`=0. `protect` becomes 1 on the clock edge that samples the next `prog_end` pulse, even when no data follows the sequence.
- R4: With `protect` at 1 and no open window, a write that is not a command step gives `allow`=0 and `suppress`=1.
- R5: With `protect` at 1, completing the enable sequence opens a window. Later writes in that window give `allow`=1. The window closes when `load_timeout` is high, and writes after that are refused again.
- R6: The disable sequence is AA to 5555, 55 to 2AAA, 80 to 5555, AA to 5555, 55 to 2AAA, then 20 to 5555. Every byte is consumed, and the sequence opens a window. `protect` falls to 0 at the edge that samples the next `prog_end`.
- R7: A write that does not match the expected next step returns the matcher to idle. That write is judged as if no sequence had been started. The one exception is AA to 5555, which starts a new sequence.
- R8: `load_timeout` aborts a partial sequence, and in the same cycle it takes priority over a write. A later A0 to 5555 is then an ordinary write.
- R9: A `prog_end` with no completed sequence pending leaves `protect` unchanged.
- R10: A command address written with non-command data, or a command byte written to the wrong address, is an ordinary write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | One-cycle pulse per host write |
| wr_addr | input | 15 | Write address |
| wr_data | input | 8 | Write data byte |
| load_timeout | input | 1 | Byte-load window expired |
| prog_end | input | 1 | Program period finished |
| protect | output | 1 | Write protection active |
| allow | output | 1 | Load this write into the page buffer |
| suppress | output | 1 | Run a no-effect program cycle |

## Verification
The checker watches four things on every cycle:
- `allow` and `suppress` are exclusive, and both are tied to the strobe.
- `suppress` never appears without `protect`.
- `protect` moves only after a `prog_end`.
- `protect` comes out of reset low.

The bench scenarios are needed for the rest:
- the exact step ordering of the two sequences;
- whether a command byte is dropped or stored;
- the lifetime of the window;
- abort by timeout;
- the restart rule on a mismatched step.

The bench exercises these with directed runs and weighted random traffic, and compares every cycle with a bench-side model.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
   typedef enum logic [2:0] {
      SQ_IDLE = 3'd0,
      SQ_AA   = 3'd1,
      SQ_55   = 3'd2,
      SQ_D80  = 3'd3,
      SQ_DAA  = 3'd4,
      SQ_D55  = 3'd5
   } seq_e;

   typedef struct packed {
      logic hit;
      seq_e nxt;
      logic fin_en;
      logic fin_dis;
   } step_t;
endpackage

// File: rtl/sdp_step_match.sv
module sdp_step_match
   import sdp_pkg::*;
#(
   parameter int ADDR_W = 15,
   parameter int DATA_W = 8,
   parameter int CMP_W  = 15,
   parameter logic [ADDR_W-1:0] ADR_P = 15'h5555,
   parameter logic [ADDR_W-1:0] ADR_Q = 15'h2AAA,
   parameter logic [DATA_W-1:0] D_LEAD = 8'hAA,
   parameter logic [DATA_W-1:0] D_SEC  = 8'h55,
   parameter logic [DATA_W-1:0] D_ENA  = 8'hA0,
   parameter logic [DATA_W-1:0] D_DSA  = 8'h80,
   parameter logic [DATA_W-1:0] D_DSB  = 8'h20
) (
   input  seq_e              cur,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   output step_t             res
);
   logic at_p, at_q;

   generate
      if (CMP_W == ADDR_W) begin : g_full
         assign at_p = (addr == ADR_P);
         assign at_q = (addr == ADR_Q);
      end else begin : g_low
         assign at_p = (addr[CMP_W-1:0] == ADR_P[CMP_W-1:0]);
         assign at_q = (addr[CMP_W-1:0] == ADR_Q[CMP_W-1:0]);
      end
   endgenerate

   logic is_lead, is_sec, is_ena, is_dsa, is_dsb;
   assign is_lead = at_p && (data == D_LEAD);
   assign is_sec  = at_q && (data == D_SEC);
   assign is_ena  = at_p && (data == D_ENA);
   assign is_dsa  = at_p && (data == D_DSA);
   assign is_dsb  = at_p && (data == D_DSB);

   always_comb begin
      res = '{hit: 1'b0, nxt: SQ_IDLE, fin_en: 1'b0, fin_dis: 1'b0};
      unique case (cur)
         SQ_AA:  if (is_sec)  res = '{1'b1, SQ_55,   1'b0, 1'b0};
         SQ_55: begin
            if (is_ena)       res = '{1'b1, SQ_IDLE, 1'b1, 1'b0};
            else if (is_dsa)  res = '{1'b1, SQ_D80,  1'b0, 1'b0};
         end
         SQ_D80: if (is_lead) res = '{1'b1, SQ_DAA,  1'b0, 1'b0};
         SQ_DAA: if (is_sec)  res = '{1'b1, SQ_D55,  1'b0, 1'b0};
         SQ_D55: if (is_dsb)  res = '{1'b1, SQ_IDLE, 1'b0, 1'b1};
         default: ;
      endcase
      if (!res.hit && is_lead) res = '{1'b1, SQ_AA, 1'b0, 1'b0};
   end
endmodule

// File: rtl/sdp_seq_track.sv
module sdp_seq_track
   import sdp_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  wr_stb,
   input  logic  load_timeout,
   input  step_t step,
   output seq_e  cur_eff,
   output logic  win_eff
);
   seq_e state_q;
   logic win_q;

   assign cur_eff = load_timeout ? SQ_IDLE : state_q;
   assign win_eff = win_q && !load_timeout;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         win_q   <= 1'b0;
      end else if (wr_stb) begin
         state_q <= step.nxt;
         win_q   <= win_eff || step.fin_en || step.fin_dis;
      end else begin
         state_q <= cur_eff;
         win_q   <= win_eff;
      end
   end
endmodule

// File: rtl/sdp_prot_state.sv
module sdp_prot_state (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_en,
   input  logic arm_dis,
   input  logic prog_end,
   output logic protect
);
   logic pend_en_q, pend_dis_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         protect    <= 1'b0;
         pend_en_q  <= 1'b0;
         pend_dis_q <= 1'b0;
      end else begin
         if (prog_end) begin
            if (pend_en_q)  protect <= 1'b1;
            if (pend_dis_q) protect <= 1'b0;
         end
         if (arm_en) begin
            pend_en_q  <= 1'b1;
            pend_dis_q <= 1'b0;
         end else if (arm_dis) begin
            pend_en_q  <= 1'b0;
            pend_dis_q <= 1'b1;
         end else if (prog_end) begin
            pend_en_q  <= 1'b0;
            pend_dis_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/sdp_cmd_seq.sv
module sdp_cmd_seq
   import sdp_pkg::*;
#(
   parameter int ADDR_W = 15,
   parameter int DATA_W = 8,
   parameter int CMP_W  = ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              load_timeout,
   input  logic              prog_end,
   output logic              protect,
   output logic              allow,
   output logic              suppress
);
   localparam logic [ADDR_W-1:0] ADR_P = ADDR_W'(15'h5555);
   localparam logic [ADDR_W-1:0] ADR_Q = ADDR_W'(15'h2AAA);

   generate
      if (ADDR_W < 15) begin : g_bad_addr
         $error("sdp_cmd_seq: ADDR_W must hold the command addresses");
      end
      if (DATA_W < 8) begin : g_bad_data
         $error("sdp_cmd_seq: DATA_W must hold a command byte");
      end
      if (CMP_W < 14 || CMP_W > ADDR_W) begin : g_bad_cmp
         $error("sdp_cmd_seq: CMP_W out of range");
      end
   endgenerate

   seq_e  cur_eff;
   logic  win_eff;
   step_t step;

   sdp_step_match #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMP_W(CMP_W),
      .ADR_P(ADR_P), .ADR_Q(ADR_Q),
      .D_LEAD(DATA_W'(8'hAA)), .D_SEC(DATA_W'(8'h55)), .D_ENA(DATA_W'(8'hA0)),
      .D_DSA(DATA_W'(8'h80)), .D_DSB(DATA_W'(8'h20))
   ) u_match (
      .cur(cur_eff), .addr(wr_addr), .data(wr_data), .res(step)
   );

   sdp_seq_track u_track (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .load_timeout(load_timeout),
      .step(step), .cur_eff(cur_eff), .win_eff(win_eff)
   );

   sdp_prot_state u_prot (
      .clk(clk), .rst_n(rst_n),
      .arm_en(wr_stb && step.fin_en), .arm_dis(wr_stb && step.fin_dis),
      .prog_end(prog_end), .protect(protect)
   );

   logic plain_wr;
   assign plain_wr = wr_stb && !step.hit;
   assign allow    = plain_wr && (!protect || win_eff);
   assign suppress = plain_wr && protect && !win_eff;
endmodule

// File: rtl/sdp_cmd_seq_chk.sv
module sdp_cmd_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic wr_stb,
   input logic prog_end,
   input logic protect,
   input logic allow,
   input logic suppress
);
   p_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({allow, suppress}));
   p_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (allow || suppress) |-> wr_stb);
   p_supp_prot_r4: assert property (@(posedge clk) disable iff (!rst_n)
      suppress |-> protect);
   p_move_on_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(protect) |-> $past(prog_end));
   p_reset_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !protect);
endmodule

bind sdp_cmd_seq sdp_cmd_seq_chk u_chk (
   .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .prog_end(prog_end),
   .protect(protect), .allow(allow), .suppress(suppress)
);

// File: tb/sdp_cmd_seq_tb.sv
module sdp_cmd_seq_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_stb = 1'b0;
   logic [14:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic load_timeout = 1'b0;
   logic prog_end = 1'b0;
   logic protect, allow, suppress;

   int checks = 0;
   int errors = 0;

   int  m_step = 0;
   bit  m_win = 0;
   int  m_arm = 0;
   bit  m_prot = 0;

   always #5 clk = ~clk;

   sdp_cmd_seq u_dut (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
      .wr_data(wr_data), .load_timeout(load_timeout), .prog_end(prog_end),
      .protect(protect), .allow(allow), .suppress(suppress)
   );

   // Reference rules: steps 0 idle, 1 AA, 2 55, 3 80, 4 second AA, 5 second 55
   function automatic void ref_step(input int st, input logic [14:0] a,
                                    input logic [7:0] d, output bit hit,
                                    output int nx, output bit fe, output bit fd);
      bit lead;
      lead = (a == 15'h5555 && d == 8'hAA);
      hit = 0; nx = 0; fe = 0; fd = 0;
      if (st == 1 && a == 15'h2AAA && d == 8'h55) begin hit = 1; nx = 2; end
      else if (st == 2 && a == 15'h5555 && d == 8'hA0) begin hit = 1; fe = 1; end
      else if (st == 2 && a == 15'h5555 && d == 8'h80) begin hit = 1; nx = 3; end
      else if (st == 3 && lead) begin hit = 1; nx = 4; end
      else if (st == 4 && a == 15'h2AAA && d == 8'h55) begin hit = 1; nx = 5; end
      else if (st == 5 && a == 15'h5555 && d == 8'h20) begin hit = 1; fd = 1; end
      else if (lead) begin hit = 1; nx = 1; end
   endfunction

   task automatic cyc(input bit stb, input logic [14:0] a, input logic [7:0] d,
                      input bit tmo, input bit pe, input string tag);
      int st, nx;
      bit w, hit, fe, fd, e_allow, e_supp;
      @(negedge clk);
      wr_stb = stb; wr_addr = a; wr_data = d; load_timeout = tmo; prog_end = pe;
      #2;
      st = tmo ? 0 : m_step;
      w  = tmo ? 0 : m_win;
      ref_step(st, a, d, hit, nx, fe, fd);
      if (!stb) begin hit = 0; fe = 0; fd = 0; end
      e_allow = stb && !hit && (!m_prot || w);
      e_supp  = stb && !hit && m_prot && !w;
      checks++;
      if (allow !== e_allow || suppress !== e_supp || protect !== m_prot) begin
         errors++;
         $display("FAIL %s: allow/supp/prot got %b%b%b exp %b%b%b", tag,
                  allow, suppress, protect, e_allow, e_supp, m_prot);
      end
      if (stb) begin m_step = nx; m_win = w || fe || fd; end
      else begin m_step = st; m_win = w; end
      if (pe) begin
         if (m_arm == 1) m_prot = 1;
         if (m_arm == 2) m_prot = 0;
         m_arm = 0;
      end
      if (fe) m_arm = 1;
      if (fd) m_arm = 2;
   endtask

   task automatic wr(input logic [14:0] a, input logic [7:0] d, input string tag);
      cyc(1, a, d, 0, 0, tag);
   endtask

   task automatic idle(input bit tmo, input bit pe, input string tag);
      cyc(0, 15'h0, 8'h0, tmo, pe, tag);
   endtask

   task automatic seq_en(input string tag);
      wr(15'h5555, 8'hAA, tag); wr(15'h2AAA, 8'h55, tag); wr(15'h5555, 8'hA0, tag);
   endtask

   function automatic logic [14:0] pick_addr();
      int r = $urandom_range(0, 9);
      if (r < 4) return 15'h5555;
      if (r < 7) return 15'h2AAA;
      return 15'($urandom);
   endfunction

   function automatic logic [7:0] pick_data();
      int r = $urandom_range(0, 11);
      case (r)
         0, 1, 2: return 8'hAA;
         3, 4, 5: return 8'h55;
         6: return 8'hA0;
         7: return 8'h80;
         8: return 8'h20;
         default: return 8'($urandom);
      endcase
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5D9));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle(0, 0, "R1 reset state");
      wr(15'h1234, 8'h3C, "R2 plain write");
      wr(15'h2AAA, 8'hAA, "R10 AA to wrong address");
      wr(15'h5555, 8'h11, "R10 other data to command address");
      seq_en("R3 enable bytes consumed");
      idle(0, 0, "R3 protect waits for program end");
      idle(1, 0, "R3 timeout");
      idle(0, 1, "R3 program end");
      idle(0, 0, "R3 protect set");
      wr(15'h0100, 8'h5A, "R4 blocked write");
      seq_en("R5 unlock");
      wr(15'h0200, 8'h77, "R5 window write");
      wr(15'h0201, 8'h78, "R5 window write 2");
      idle(1, 0, "R5 window close");
      wr(15'h0202, 8'h79, "R5 blocked after window");
      idle(0, 1, "R9 re-enable keeps protect");
      idle(0, 1, "R9 idle program end");
      wr(15'h5555, 8'hAA, "R7 start");
      wr(15'h0300, 8'h01, "R7 mismatch blocked");
      wr(15'h2AAA, 8'h55, "R7 stale step not matched");
      wr(15'h5555, 8'hAA, "R7 restart");
      wr(15'h5555, 8'hAA, "R7 restart on lead");
      wr(15'h2AAA, 8'h55, "R7 second step");
      idle(1, 0, "R8 abort");
      wr(15'h5555, 8'hA0, "R8 A0 after abort blocked");
      cyc(1, 15'h5555, 8'hAA, 1, 0, "R8 timeout with write");
      idle(1, 0, "R8 close");
      wr(15'h5555, 8'hAA, "R6 d1"); wr(15'h2AAA, 8'h55, "R6 d2");
      wr(15'h5555, 8'h80, "R6 d3"); wr(15'h5555, 8'hAA, "R6 d4");
      wr(15'h2AAA, 8'h55, "R6 d5"); wr(15'h5555, 8'h20, "R6 d6");
      wr(15'h0400, 8'h42, "R6 window write");
      idle(1, 0, "R6 timeout");
      idle(0, 1, "R6 program end");
      idle(0, 0, "R6 protect cleared");
      wr(15'h0500, 8'h43, "R6 plain after disable");
      idle(0, 1, "R9 no pending");
      for (int i = 0; i < 4000; i++) begin
         bit stb = ($urandom_range(0, 9) < 7);
         bit tmo = ($urandom_range(0, 19) == 0);
         bit pe  = ($urandom_range(0, 19) == 0);
         cyc(stb, pick_addr(), pick_data(), tmo, pe, "R2 random");
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule